// File: doc/BRIEF.md
# Four-Instruction Load/Store Processor Core

A small single-cycle processor that runs a four-instruction subset of a 32-bit load/store instruction set: register add, register subtract, load word and store word. Each rising clock edge retires one instruction. The instruction at the program counter is read from an internal instruction memory and decoded. The core then produces either an arithmetic result or a byte address. It writes the register file or the data memory and moves the program counter on by 4.

Both memories have a plain write port for preloading, used while the core is held in reset. Two combinational debug read ports expose any register and any data word. Executing an undefined encoding or a misaligned memory access sets a sticky halt flag. The faulting instruction has no effect, and the core stays frozen until the next reset. Memory addresses are word indices taken from the byte address, so addresses wrap at the memory size.

Top module: `quad_core`

## Requirements
- R1: While rst_ni is low, pc_o reads 0, halt_o reads 0 and every register reads 0 through the debug port.
- R2: An instruction with bits[31:26]=0, bits[10:6]=0 and bits[5:0]=32 writes reg[bits 25:21] + reg[bits 20:16], modulo 2^32, into reg[bits 15:11].
- R3: An instruction with bits[31:26]=0, bits[10:6]=0 and bits[5:0]=34 writes reg[bits 25:21] − reg[bits 20:16], modulo 2^32, into reg[bits 15:11].
- R4: Opcode 35 in bits[31:26] loads the data word at byte address reg[bits 25:21] + offset[15:0] into reg[bits 20:16].
- R5: Opcode 43 in bits[31:26] stores reg[bits 20:16] into the data word at byte address reg[bits 25:21] + offset[15:0].
- R6: The 16-bit offset is sign-extended before the add, so offsets from 0x8000 to 0xFFFF point below the base.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: Every instruction that does not fault advances pc_o by exactly 4. The instruction memory word used is pc_o divided by 4.
- R9: Any other opcode, any other funct value, or a nonzero bits[10:6] in an arithmetic instruction writes nothing and leaves pc_o unchanged. It raises halt_o on the following cycle. halt_o then stays high, with pc_o frozen, until reset.
- R10: A load or store whose byte address has nonzero bits[1:0] writes neither the register file nor memory, and halts the core as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_we_i | input | 1 | Instruction memory preload write enable |
| imem_waddr_i | input | IAW | Instruction memory preload word index |
| imem_wdata_i | input | 32 | Instruction memory preload data |
| dmem_we_i | input | 1 | Data memory preload write enable (wins over a core store) |
| dmem_waddr_i | input | DAW | Data memory preload word index |
| dmem_wdata_i | input | 32 | Data memory preload data |
| dbg_reg_sel_i | input | 5 | Register number for the debug read |
| dbg_reg_o | output | 32 | Debug register value |
| dbg_mem_sel_i | input | DAW | Data word index for the debug read |
| dbg_mem_o | output | 32 | Debug data word |
| pc_o | output | 32 | Program counter |
| halt_o | output | 1 | Sticky fault/halt flag |

## Verification
The hardest cases to reach are faults that come after state has already built up. Examples are a misaligned store from a register that a previous load filled, and a bad funct field whose destination register already holds a live value. Only these cases show whether the faulting write was really suppressed. The stimulus reaches them by resetting the core and preloading a two-instruction program. The first instruction loads a known value, and the second is the faulting one. The bench then reads the destination register or memory word back through the debug ports, together with the frozen pc_o. Negative offsets are checked by using a register computed earlier in the program as the base.

// File: rtl/qc_pkg.sv
package qc_pkg;
  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OP_ARITH = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;

  typedef enum logic [2:0] {K_ADD, K_SUB, K_LOAD, K_STORE, K_BAD} kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [4:0]       rs;
    logic [4:0]       rt;
    logic [4:0]       rd;
    logic [XLEN-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/qc_decode.sv
module qc_decode
  import qc_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output dec_t            dec_o
);
  logic [5:0] op, fn;
  logic [4:0] sh;

  assign op = instr_i[31:26];
  assign sh = instr_i[10:6];
  assign fn = instr_i[5:0];

  always_comb begin
    dec_o.rs   = instr_i[25:21];
    dec_o.rt   = instr_i[20:16];
    dec_o.rd   = instr_i[15:11];
    dec_o.imm  = {{(XLEN-16){instr_i[15]}}, instr_i[15:0]};
    dec_o.kind = K_BAD;
    unique case (op)
      OP_ARITH: begin
        if (sh == 5'd0) begin
          if (fn == FN_ADD)      dec_o.kind = K_ADD;
          else if (fn == FN_SUB) dec_o.kind = K_SUB;
        end
      end
      OP_LOAD:  dec_o.kind = K_LOAD;
      OP_STORE: dec_o.kind = K_STORE;
      default:  dec_o.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/qc_regfile.sv
module qc_regfile #(
  parameter  int unsigned NREG = 32,
  parameter  int unsigned W    = 32,
  parameter  int unsigned NRD  = 3,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [W-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output logic [NRD-1:0][W-1:0]  rdata_o
);
  logic [NREG-1:0][W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = (raddr_i[g] == '0) ? '0 : q[raddr_i[g]];
  end
endmodule

// File: rtl/qc_ram.sv
module qc_ram #(
  parameter  int unsigned W     = 32,
  parameter  int unsigned DEPTH = 64,
  parameter  int unsigned NRD   = 1,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [W-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output logic [NRD-1:0][W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem[raddr_i[g]];
  end
endmodule

// File: rtl/quad_core.sv
module quad_core
  import qc_pkg::*;
#(
  parameter  int unsigned IMEM_WORDS = 64,
  parameter  int unsigned DMEM_WORDS = 64,
  localparam int unsigned IAW        = $clog2(IMEM_WORDS),
  localparam int unsigned DAW        = $clog2(DMEM_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            imem_we_i,
  input  logic [IAW-1:0]  imem_waddr_i,
  input  logic [31:0]     imem_wdata_i,
  input  logic            dmem_we_i,
  input  logic [DAW-1:0]  dmem_waddr_i,
  input  logic [31:0]     dmem_wdata_i,
  input  logic [4:0]      dbg_reg_sel_i,
  output logic [31:0]     dbg_reg_o,
  input  logic [DAW-1:0]  dbg_mem_sel_i,
  output logic [31:0]     dbg_mem_o,
  output logic [31:0]     pc_o,
  output logic            halt_o
);
  logic [XLEN-1:0] pc_q;
  logic            halt_q;
  logic [XLEN-1:0] ir;
  dec_t            dec;
  kind_e           kind;

  logic [2:0][4:0]      rf_raddr;
  logic [2:0][XLEN-1:0] rf_rdata;
  logic [XLEN-1:0]      rs_val, rt_val;
  logic                 rf_we;
  logic [4:0]           rf_waddr;
  logic [XLEN-1:0]      rf_wdata;

  logic [1:0][DAW-1:0]  dm_raddr;
  logic [1:0][XLEN-1:0] dm_rdata;
  logic                 dm_we;
  logic [DAW-1:0]       dm_waddr;
  logic [XLEN-1:0]      dm_wdata;

  logic [XLEN-1:0] ea;
  logic            is_mem, misalign, fault, step;

  // fetch: word index from the byte PC
  qc_ram #(.W(XLEN), .DEPTH(IMEM_WORDS), .NRD(1)) u_imem (
    .clk_i   (clk_i),
    .we_i    (imem_we_i),
    .waddr_i (imem_waddr_i),
    .wdata_i (imem_wdata_i),
    .raddr_i (pc_q[2 +: IAW]),
    .rdata_o (ir)
  );

  qc_decode u_dec (
    .instr_i (ir),
    .dec_o   (dec)
  );
  assign kind = dec.kind;

  // read ports: 0 = rs, 1 = rt, 2 = debug
  assign rf_raddr = {dbg_reg_sel_i, dec.rt, dec.rs};
  assign rs_val   = rf_rdata[0];
  assign rt_val   = rf_rdata[1];
  assign dbg_reg_o = rf_rdata[2];

  qc_regfile #(.NREG(32), .W(XLEN), .NRD(3)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  assign ea       = rs_val + dec.imm;
  assign is_mem   = (kind == K_LOAD) || (kind == K_STORE);
  assign misalign = is_mem && (ea[1:0] != 2'b00);
  assign fault    = (kind == K_BAD) || misalign;
  assign step     = !halt_q && !fault;

  always_comb begin
    unique case (kind)
      K_ADD:   rf_wdata = rs_val + rt_val;
      K_SUB:   rf_wdata = rs_val - rt_val;
      default: rf_wdata = dm_rdata[0];
    endcase
  end
  assign rf_we    = step && (kind inside {K_ADD, K_SUB, K_LOAD});
  assign rf_waddr = (kind == K_LOAD) ? dec.rt : dec.rd;

  // preload port takes priority over a core store
  assign dm_we    = dmem_we_i || (step && kind == K_STORE);
  assign dm_waddr = dmem_we_i ? dmem_waddr_i : ea[2 +: DAW];
  assign dm_wdata = dmem_we_i ? dmem_wdata_i : rt_val;
  assign dm_raddr = {dbg_mem_sel_i, ea[2 +: DAW]};
  assign dbg_mem_o = dm_rdata[1];

  qc_ram #(.W(XLEN), .DEPTH(DMEM_WORDS), .NRD(2)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dm_we),
    .waddr_i (dm_waddr),
    .wdata_i (dm_wdata),
    .raddr_i (dm_raddr),
    .rdata_o (dm_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
    end else begin
      if (step)                pc_q   <= pc_q + 32'd4;
      if (!halt_q && fault)    halt_q <= 1'b1;
    end
  end

  assign pc_o   = pc_q;
  assign halt_o = halt_q;

  logic unused_ok;
  assign unused_ok = ^{ea[XLEN-1:DAW+2], pc_q[XLEN-1:IAW+2], pc_q[1:0]};
endmodule

// File: rtl/quad_core_chk.sv
module quad_core_chk
  import qc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_o,
  input logic        halt_o,
  input logic [4:0]  dbg_reg_sel_i,
  input logic [31:0] dbg_reg_o,
  input kind_e       kind,
  input logic [1:0]  ea_lo,
  input logic        rf_we
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (pc_o == 32'd0 && !halt_o);
    end
  end

  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  a_r9_pc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> $stable(pc_o));

  a_r9_bad_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && kind == K_BAD) |=> (halt_o && $stable(pc_o)));

  a_r10_misalign_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && (kind == K_LOAD || kind == K_STORE) && ea_lo != 2'b00)
      |=> (halt_o && $stable(pc_o)));

  a_r8_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && kind != K_BAD && !((kind == K_LOAD || kind == K_STORE) && ea_lo != 2'b00))
      |=> (pc_o == $past(pc_o) + 32'd4));

  a_r7_zero_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_reg_sel_i == 5'd0) |-> (dbg_reg_o == 32'd0));

  a_r9_no_write_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !rf_we);
endmodule

bind quad_core quad_core_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pc_o          (pc_o),
  .halt_o        (halt_o),
  .dbg_reg_sel_i (dbg_reg_sel_i),
  .dbg_reg_o     (dbg_reg_o),
  .kind          (kind),
  .ea_lo         (ea[1:0]),
  .rf_we         (rf_we)
);

// File: tb/quad_core_tb.sv
`timescale 1ns/1ps
module quad_core_tb;
  localparam int IAW = 6;
  localparam int DAW = 6;
  localparam int NV  = 15;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           imem_we = 1'b0;
  logic [IAW-1:0] imem_waddr = '0;
  logic [31:0]    imem_wdata = '0;
  logic           dmem_we = 1'b0;
  logic [DAW-1:0] dmem_waddr = '0;
  logic [31:0]    dmem_wdata = '0;
  logic [4:0]     reg_sel = '0;
  logic [31:0]    reg_val;
  logic [DAW-1:0] mem_sel = '0;
  logic [31:0]    mem_val;
  logic [31:0]    pc;
  logic           halt;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  quad_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .imem_we_i(imem_we), .imem_waddr_i(imem_waddr), .imem_wdata_i(imem_wdata),
    .dmem_we_i(dmem_we), .dmem_waddr_i(dmem_waddr), .dmem_wdata_i(dmem_wdata),
    .dbg_reg_sel_i(reg_sel), .dbg_reg_o(reg_val),
    .dbg_mem_sel_i(mem_sel), .dbg_mem_o(mem_val),
    .pc_o(pc), .halt_o(halt)
  );

  // {instr, 0=reg/1=mem, select, expected}
  localparam logic [70:0] VEC [NV] = '{
    {{6'd35, 5'd0,  5'd8,  16'd0},               1'b0, 6'd8,  32'd5},          // R4
    {{6'd35, 5'd0,  5'd9,  16'd4},               1'b0, 6'd9,  32'd7},          // R4
    {{6'd0,  5'd8,  5'd9,  5'd10, 5'd0, 6'd32},  1'b0, 6'd10, 32'd12},         // R2
    {{6'd0,  5'd8,  5'd9,  5'd11, 5'd0, 6'd34},  1'b0, 6'd11, 32'hFFFF_FFFE},  // R3
    {{6'd35, 5'd0,  5'd12, 16'd8},               1'b0, 6'd12, 32'hFFFF_FFFF},  // R4
    {{6'd0,  5'd12, 5'd9,  5'd13, 5'd0, 6'd32},  1'b0, 6'd13, 32'd6},          // R2 wrap
    {{6'd35, 5'd0,  5'd14, 16'd12},              1'b0, 6'd14, 32'h8000_0000},  // R4
    {{6'd0,  5'd14, 5'd9,  5'd15, 5'd0, 6'd34},  1'b0, 6'd15, 32'h7FFF_FFF9},  // R3 wrap
    {{6'd0,  5'd8,  5'd9,  5'd0,  5'd0, 6'd32},  1'b0, 6'd0,  32'd0},          // R7
    {{6'd35, 5'd0,  5'd16, 16'd40},              1'b0, 6'd16, 32'd100},        // R4
    {{6'd35, 5'd10, 5'd18, 16'hFFFC},            1'b0, 6'd18, 32'hFFFF_FFFF},  // R6
    {{6'd43, 5'd0,  5'd10, 16'd16},              1'b1, 6'd4,  32'd12},         // R5
    {{6'd43, 5'd10, 5'd13, 16'hFFF8},            1'b1, 6'd1,  32'd6},          // R5 R6
    {{6'd35, 5'd0,  5'd19, 16'd4},               1'b0, 6'd19, 32'd6},          // R4
    {{6'd0,  5'd0,  5'd9,  5'd20, 5'd0, 6'd34},  1'b0, 6'd20, 32'hFFFF_FFF9}   // R7 R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_imem(input int idx, input logic [31:0] d);
    @(negedge clk);
    imem_we = 1'b1; imem_waddr = IAW'(idx); imem_wdata = d;
    @(negedge clk);
    imem_we = 1'b0;
  endtask

  task automatic put_dmem(input int idx, input logic [31:0] d);
    @(negedge clk);
    dmem_we = 1'b1; dmem_waddr = DAW'(idx); dmem_wdata = d;
    @(negedge clk);
    dmem_we = 1'b0;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 pc", pc, 32'd0);
    check("R1 halt", {31'd0, halt}, 32'd0);
    begin
      int bad = 0;
      for (int r = 0; r < 32; r++) begin
        reg_sel = 5'(r); #0.1;
        if (reg_val !== 32'd0) bad++;
      end
      check("R1 regs cleared", 32'(bad), 32'd0);
    end
  endtask

  task automatic leave_reset();
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // preload while reset held
    for (int i = 0; i < 64; i++) put_imem(i, 32'd0);
    for (int i = 0; i < NV; i++) put_imem(i, VEC[i][70:39]);
    put_imem(NV, {6'd35, 5'd0, 5'd21, 16'd2});  // misaligned load
    put_dmem(0, 32'd5);
    put_dmem(1, 32'd7);
    put_dmem(2, 32'hFFFF_FFFF);
    put_dmem(3, 32'h8000_0000);
    put_dmem(10, 32'd100);
    enter_reset();
    leave_reset();

    for (int i = 0; i < NV; i++) begin
      after_edge();
      if (VEC[i][38]) mem_sel = VEC[i][37:32];
      else            reg_sel = VEC[i][36:32];
      #1;
      check($sformatf("R2-5 vec %0d", i), VEC[i][38] ? mem_val : reg_val, VEC[i][31:0]);
      check("R8 pc step", pc, 32'(4 * (i + 1)));
      check("R9 no halt", {31'd0, halt}, 32'd0);
    end

    // R10: misaligned load halts, no write, pc frozen
    after_edge();
    reg_sel = 5'd21; #1;
    check("R10 load no write", reg_val, 32'd0);
    check("R10 halt", {31'd0, halt}, 32'd1);
    check("R10 pc held", pc, 32'd60);
    repeat (3) after_edge();
    check("R9 halt sticky", {31'd0, halt}, 32'd1);
    check("R9 pc frozen", pc, 32'd60);

    // R9: bad funct must not overwrite r8
    enter_reset();
    put_imem(0, {6'd35, 5'd0, 5'd8, 16'd0});
    put_imem(1, {6'd0, 5'd0, 5'd0, 5'd8, 5'd0, 6'd33});
    leave_reset();
    after_edge();
    after_edge();
    reg_sel = 5'd8; #1;
    check("R9 bad funct no write", reg_val, 32'd5);
    check("R9 bad funct halt", {31'd0, halt}, 32'd1);
    check("R9 bad funct pc", pc, 32'd4);

    // R9: undefined opcode
    enter_reset();
    put_imem(0, {6'd2, 26'd0});
    leave_reset();
    after_edge();
    check("R9 bad opcode halt", {31'd0, halt}, 32'd1);
    check("R9 bad opcode pc", pc, 32'd0);

    // R9: nonzero shift field on add
    enter_reset();
    put_imem(0, {6'd0, 5'd0, 5'd0, 5'd8, 5'd1, 6'd32});
    leave_reset();
    after_edge();
    check("R9 shamt halt", {31'd0, halt}, 32'd1);
    check("R9 shamt pc", pc, 32'd0);

    // R10: misaligned store leaves memory untouched
    enter_reset();
    put_imem(0, {6'd35, 5'd0, 5'd8, 16'd0});
    put_imem(1, {6'd43, 5'd0, 5'd8, 16'd5});
    leave_reset();
    after_edge();
    after_edge();
    mem_sel = 6'd1; #1;
    check("R10 store no write", mem_val, 32'd6);
    check("R10 store halt", {31'd0, halt}, 32'd1);
    check("R10 store pc", pc, 32'd4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule